// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block sits between an interrupt source array and one processor. The source array offers a source index whenever a source has work for this processor; the presenter decides whether the offer is accepted, and whether to drive the processor's normal or critical interrupt line. It keeps two bit sets, one bit per source: the raised set holds accepted sources that wait for acknowledge, and the in-service set holds acknowledged sources that wait for end-of-interrupt. Priorities, vectors, sense type and critical steering come in from the source array as flat per-source vectors. The presenter keeps each source's activity flag and reports it on `act_o`.

The processor uses a small register port. Reading the acknowledge register returns the vector of the best raised source, checks its priority again and moves it into service. Writing the end-of-interrupt register retires the best in-service source and raises the line again when a waiting source may now preempt. A 4-bit task priority register masks low-priority offers, and an 8-bit spurious vector register supplies the value returned when no valid source can be handed out. The line driver is a four-state machine: `OUT_QUIET` (both lines low), `OUT_NORM` (normal line high), `OUT_CRIT` (critical line high) and `OUT_BOTH`. The transitions are: raise-normal (`OUT_QUIET`→`OUT_NORM`, `OUT_CRIT`→`OUT_BOTH`), raise-critical (`OUT_QUIET`→`OUT_CRIT`, `OUT_NORM`→`OUT_BOTH`) and acknowledge-drop (any state→`OUT_QUIET`). Reset enters `OUT_QUIET`.

Register addresses on `reg_addr`: 0 task priority (read/write), 1 spurious vector (read/write), 2 identity (read only), 3 acknowledge (read), 4 end-of-interrupt (write; reads as 0). Any other address reads 0 and ignores writes.

Top module: `irq_presenter`

## Requirements
- R1: An offer whose source priority is less than or equal to the task priority is dropped. An offer for a source whose raised bit is already set is dropped as a missed interrupt. Neither kind changes the raised set.
- R2: An accepted offer sets the source's raised bit and its activity bit (`act_o[src]`) at the next clock edge.
- R3: An accepted offer moves the line state machine by raise-normal or raise-critical only if its priority is at least the highest priority already raised, and the in-service set is empty or its priority is strictly greater than the highest in-service priority.
- R4: The best raised or in-service source is the one with the strictly greatest priority; among equal priorities the lowest source index wins.
- R5: A read of address 3 takes acknowledge-drop, so both lines are low the cycle after. With an empty raised set it returns the spurious vector.
- R6: On acknowledge, if the best raised source has activity clear or priority not above the task priority, its activity is cleared and the spurious vector is returned. Otherwise it enters the in-service set and its vector is returned. Its raised bit is cleared in both cases.
- R7: Acknowledge of an edge-sensed source (`src_level` bit 0) clears its activity and pulses its bit of `pend_clr_o` for one cycle. A level-sensed source keeps its activity after a valid acknowledge.
- R8: A write to address 4 removes the best in-service source. The line is then raised again if the raised set is non-empty and either the in-service set is now empty or the best raised priority exceeds the best remaining in-service priority.
- R9: After reset both lines are low, the task priority reads 0xF (blocking every source) and the spurious vector reads 0xFF. A task priority write keeps `reg_wdata[3:0]`. A spurious write keeps all 8 bits.
- R10: When `crit_en` is 1 and the source's `src_crit` bit is 1, the raise goes to `cirq_o` instead of `irq_o`. This holds for offers and for the raise after end-of-interrupt.
- R11: Read data appears on `reg_rdata` the cycle after `reg_rd`. Address 2 returns the parameter `CPU_IDX`, and address 4 returns 0.
- R12: An offer in the same cycle as a register read or write is dropped: the raised set, activity and lines do not change because of it.
- R13: A `lvl_drop` bit clears that source's activity flag at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | An offer is presented this cycle |
| offer_src | input | SRC_W | Index of the offered source |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, source i at bits [i*PRIO_W +: PRIO_W] |
| src_vec | input | NUM_SRC*VEC_W | Per-source vector, source i at bits [i*VEC_W +: VEC_W] |
| src_level | input | NUM_SRC | 1 = level-sensed source, 0 = edge-sensed |
| src_crit | input | NUM_SRC | Critical steering bit of each source for this CPU |
| crit_en | input | 1 | Enables critical steering |
| lvl_drop | input | NUM_SRC | Clears the activity flag of each marked source |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | VEC_W | Write data |
| reg_rdata | output | VEC_W | Read data, valid the cycle after reg_rd |
| irq_o | output | 1 | Normal interrupt line |
| cirq_o | output | 1 | Critical interrupt line |
| act_o | output | NUM_SRC | Activity flag of each source |
| pend_clr_o | output | NUM_SRC | One-cycle pulse telling the source array to clear a pending flag |

## Verification
All results are registered once. An offer, an acknowledge or an end-of-interrupt drives the edge that follows, so `irq_o`, `cirq_o`, `act_o`, `pend_clr_o` and `reg_rdata` are due one cycle after the stimulus. The bench drives every stimulus on a falling edge, holds it through one rising edge, and compares on the next falling edge. A task priority or spurious write takes effect for accesses that start in the cycle after the write. The sweep runs every source priority against every task priority and computes the accept decision and the acknowledge vector as plain arithmetic. Directed sequences then follow the raised and in-service sets through preemption, ties, re-checks and the raise after end-of-interrupt.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_TPR  = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_SPUR = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_WHO  = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_ACK  = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_EOI  = 3'd4;

    typedef enum logic [1:0] {
        OUT_QUIET = 2'd0,
        OUT_NORM  = 2'd1,
        OUT_CRIT  = 2'd2,
        OUT_BOTH  = 2'd3
    } out_state_e;

endpackage

// File: rtl/pri_pick.sv
module pri_pick #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        mask,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output logic                      any,
    output logic [SRC_W-1:0]          idx,
    output logic [PRIO_W-1:0]         best
);

    // Strict greater-than keeps the lowest index on a tie.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (mask[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best)) begin
                any  = 1'b1;
                idx  = SRC_W'(i);
                best = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_out_ctl.sv
module irq_out_ctl
    import irq_presenter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_n,
    input  logic raise_c,
    input  logic drop,
    output logic irq_o,
    output logic cirq_o
);

    out_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (drop) begin
            state_d = OUT_QUIET;
        end else begin
            unique case (state_q)
                OUT_QUIET: begin
                    if (raise_c)      state_d = OUT_CRIT;
                    else if (raise_n) state_d = OUT_NORM;
                end
                OUT_NORM: if (raise_c) state_d = OUT_BOTH;
                OUT_CRIT: if (raise_n) state_d = OUT_BOTH;
                OUT_BOTH: state_d = OUT_BOTH;
            endcase
        end
    end

    always_comb begin
        irq_o  = 1'b0;
        cirq_o = 1'b0;
        unique case (state_q)
            OUT_QUIET: ;
            OUT_NORM:  irq_o  = 1'b1;
            OUT_CRIT:  cirq_o = 1'b1;
            OUT_BOTH: begin
                irq_o  = 1'b1;
                cirq_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irq_presenter_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 8,
    parameter int CPU_IDX = 0,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC*VEC_W-1:0]  src_vec,
    input  logic [NUM_SRC-1:0]        src_level,
    input  logic [NUM_SRC-1:0]        src_crit,
    input  logic                      crit_en,
    input  logic [NUM_SRC-1:0]        lvl_drop,
    input  logic                      reg_rd,
    input  logic                      reg_wr,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [VEC_W-1:0]          reg_wdata,
    output logic [VEC_W-1:0]          reg_rdata,
    output logic                      irq_o,
    output logic                      cirq_o,
    output logic [NUM_SRC-1:0]        act_o,
    output logic [NUM_SRC-1:0]        pend_clr_o
);

    localparam int NPICK = 3;   // 0: raised, 1: in service, 2: in service after retire

    logic [NUM_SRC-1:0] raised_q, svc_q, act_q, pclr_q;
    logic [PRIO_W-1:0]  tpr_q;
    logic [VEC_W-1:0]   spur_q, rdata_q;

    logic [NUM_SRC-1:0] pick_mask [NPICK];
    logic               pick_any  [NPICK];
    logic [SRC_W-1:0]   pick_idx  [NPICK];
    logic [PRIO_W-1:0]  pick_prio [NPICK];

    assign pick_mask[0] = raised_q;
    assign pick_mask[1] = svc_q;
    assign pick_mask[2] = svc_q & ~(NUM_SRC'(1) << pick_idx[1]);

    for (genvar g = 0; g < NPICK; g++) begin : g_pick
        pri_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
            .mask (pick_mask[g]),
            .prio (src_prio),
            .any  (pick_any[g]),
            .idx  (pick_idx[g]),
            .best (pick_prio[g])
        );
    end

    logic              reg_busy, accept, show, ack, ack_ok, eoi, rearm;
    logic [PRIO_W-1:0] off_prio;
    logic [VEC_W-1:0]  top_vec;

    assign reg_busy = reg_rd | reg_wr;
    assign off_prio = src_prio[offer_src*PRIO_W +: PRIO_W];
    assign accept   = offer_valid && !reg_busy && (off_prio > tpr_q) && !raised_q[offer_src];
    assign show     = accept && (!pick_any[0] || off_prio >= pick_prio[0])
                             && (!pick_any[1] || off_prio >  pick_prio[1]);

    assign ack    = reg_rd && (reg_addr == ADDR_ACK);
    assign ack_ok = pick_any[0] && act_q[pick_idx[0]] && (pick_prio[0] > tpr_q);
    assign eoi    = reg_wr && (reg_addr == ADDR_EOI);
    assign rearm  = eoi && pick_any[0] && (!pick_any[2] || pick_prio[0] > pick_prio[2]);

    assign top_vec = src_vec[pick_idx[0]*VEC_W +: VEC_W];

    logic raise_n, raise_c, show_c, rearm_c;
    assign show_c  = crit_en && src_crit[offer_src];
    assign rearm_c = crit_en && src_crit[pick_idx[0]];
    assign raise_c = (show && show_c) || (rearm && rearm_c);
    assign raise_n = (show && !show_c) || (rearm && !rearm_c);

    irq_out_ctl u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_n (raise_n),
        .raise_c (raise_c),
        .drop    (ack),
        .irq_o   (irq_o),
        .cirq_o  (cirq_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q <= '0;
            svc_q    <= '0;
            act_q    <= '0;
            pclr_q   <= '0;
            tpr_q    <= '1;
            spur_q   <= '1;
            rdata_q  <= '0;
        end else begin
            logic [NUM_SRC-1:0] act_n, raised_n, svc_n, pclr_n;
            act_n    = act_q & ~lvl_drop;
            raised_n = raised_q;
            svc_n    = svc_q;
            pclr_n   = '0;

            if (accept) begin
                raised_n[offer_src] = 1'b1;
                act_n[offer_src]    = 1'b1;
            end

            if (ack && pick_any[0]) begin
                raised_n[pick_idx[0]] = 1'b0;
                if (ack_ok) svc_n[pick_idx[0]] = 1'b1;
                if (!ack_ok || !src_level[pick_idx[0]]) act_n[pick_idx[0]] = 1'b0;
                if (!src_level[pick_idx[0]]) pclr_n[pick_idx[0]] = 1'b1;
            end

            if (eoi && pick_any[1]) svc_n[pick_idx[1]] = 1'b0;

            if (reg_wr && reg_addr == ADDR_TPR)  tpr_q  <= reg_wdata[PRIO_W-1:0];
            if (reg_wr && reg_addr == ADDR_SPUR) spur_q <= reg_wdata;

            if (reg_rd) begin
                case (reg_addr)
                    ADDR_TPR:  rdata_q <= VEC_W'(tpr_q);
                    ADDR_SPUR: rdata_q <= spur_q;
                    ADDR_WHO:  rdata_q <= VEC_W'(CPU_IDX);
                    ADDR_ACK:  rdata_q <= ack_ok ? top_vec : spur_q;
                    default:   rdata_q <= '0;
                endcase
            end

            raised_q <= raised_n;
            svc_q    <= svc_n;
            act_q    <= act_n;
            pclr_q   <= pclr_n;
        end
    end

    assign reg_rdata  = rdata_q;
    assign act_o      = act_q;
    assign pend_clr_o = pclr_q;

endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk
    import irq_presenter_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      offer_valid,
    input logic [SRC_W-1:0]          offer_src,
    input logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input logic                      reg_rd,
    input logic                      reg_wr,
    input logic [REG_AW-1:0]         reg_addr,
    input logic                      irq_o,
    input logic                      cirq_o,
    input logic [NUM_SRC-1:0]        act_o,
    input logic [NUM_SRC-1:0]        pend_clr_o,
    input logic [PRIO_W-1:0]         tpr_q,
    input logic [NUM_SRC-1:0]        raised_q,
    input logic [NUM_SRC-1:0]        svc_q
);

    logic [PRIO_W-1:0] o_prio;
    logic              quiet_port, o_refused, o_taken;
    assign o_prio     = src_prio[offer_src*PRIO_W +: PRIO_W];
    assign quiet_port = !reg_rd && !reg_wr;
    assign o_refused  = offer_valid && quiet_port && (o_prio <= tpr_q || raised_q[offer_src]);
    assign o_taken    = offer_valid && quiet_port && (o_prio > tpr_q) && !raised_q[offer_src];

    // R1: a refused offer leaves the raised set untouched
    a_r1_refused_offer: assert property (@(posedge clk) disable iff (!rst_n)
        o_refused |=> $stable(raised_q));

    // R2: a taken offer shows up in raised set and activity
    a_r2_offer_taken: assert property (@(posedge clk) disable iff (!rst_n)
        o_taken |=> (raised_q[$past(offer_src)] && act_o[$past(offer_src)]));

    // R5: acknowledge leaves both lines low
    a_r5_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_ACK) |=> (!irq_o && !cirq_o));

    // R8: end-of-interrupt retires exactly one in-service source
    a_r8_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EOI && svc_q != '0)
            |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // R7: at most one pending-clear pulse per acknowledge
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr_o));

endmodule

bind irq_presenter irq_presenter_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .src_prio    (src_prio),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .irq_o       (irq_o),
    .cirq_o      (cirq_o),
    .act_o       (act_o),
    .pend_clr_o  (pend_clr_o),
    .tpr_q       (tpr_q),
    .raised_q    (raised_q),
    .svc_q       (svc_q)
);

// File: tb/sim_irq_presenter.sv
`timescale 1ns/1ps
module sim_irq_presenter;

    localparam int NS = 8;
    localparam int PW = 4;
    localparam int VW = 8;
    localparam int SW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          offer_valid = 1'b0;
    logic [SW-1:0] offer_src = '0;
    logic [NS*PW-1:0] src_prio;
    logic [NS*VW-1:0] src_vec;
    logic [NS-1:0] src_level = 8'h80;
    logic [NS-1:0] src_crit  = 8'h08;
    logic          crit_en = 1'b0;
    logic [NS-1:0] lvl_drop = '0;
    logic          reg_rd = 1'b0, reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [VW-1:0] reg_wdata = '0;
    logic [VW-1:0] reg_rdata;
    logic          irq_o, cirq_o;
    logic [NS-1:0] act_o, pend_clr_o;

    logic [PW-1:0] prio_tb [NS];
    int total = 0, bad = 0;
    logic [VW-1:0] rv;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            src_prio[i*PW +: PW] = prio_tb[i];
            src_vec[i*VW +: VW]  = VW'(8'h40 + i);
        end
    end

    irq_presenter #(.NUM_SRC(NS), .PRIO_W(PW), .VEC_W(VW), .CPU_IDX(0)) u0 (
        .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
        .src_prio(src_prio), .src_vec(src_vec), .src_level(src_level),
        .src_crit(src_crit), .crit_en(crit_en), .lvl_drop(lvl_drop),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .cirq_o(cirq_o),
        .act_o(act_o), .pend_clr_o(pend_clr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [VW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        rv = reg_rdata;
    endtask

    task automatic do_offer(input int s);
        offer_valid = 1'b1; offer_src = SW'(s);
        @(negedge clk);
        offer_valid = 1'b0;
    endtask

    task automatic ack_expect(input int exp, input string req);
        do_rd(3'd3);
        chk(rv == VW'(exp), req, rv, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        prio_tb[0] = 0;  prio_tb[1] = 12; prio_tb[2] = 5; prio_tb[3] = 7;
        prio_tb[4] = 6;  prio_tb[5] = 7;  prio_tb[6] = 9; prio_tb[7] = 10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk(irq_o == 0 && cirq_o == 0, "R9 lines low", {irq_o, cirq_o}, 0);
        do_rd(3'd0); chk(rv == 8'h0F, "R9 tpr reset", rv, 8'h0F);
        do_rd(3'd1); chk(rv == 8'hFF, "R9 spurious reset", rv, 8'hFF);
        // R11 identity / eoi read
        do_rd(3'd2); chk(rv == 8'h00, "R11 identity", rv, 0);
        do_rd(3'd4); chk(rv == 8'h00, "R11 eoi reads zero", rv, 0);
        // R1 reset tpr blocks everything
        do_offer(1);
        chk(irq_o == 0 && act_o == 0, "R1 reset tpr blocks", act_o, 0);
        ack_expect(8'hFF, "R5 empty ack spurious");
        // R9 tpr write keeps low 4 bits
        do_wr(3'd0, 8'hA7);
        do_rd(3'd0); chk(rv == 8'h07, "R9 tpr masked", rv, 8'h07);

        // R1 R3 sweep of source priority against task priority
        for (int t = 0; t < 16; t++) begin
            for (int p = 0; p < 16; p++) begin
                bit take;
                take = (p > t);
                prio_tb[0] = PW'(p);
                do_wr(3'd0, VW'(t));
                do_offer(0);
                chk(irq_o == take && act_o[0] == take, "R1 R3 sweep accept", {irq_o, act_o[0]}, {take, take});
                ack_expect(take ? 8'h40 : 8'hFF, "R6 sweep ack vector");
                if (take) do_wr(3'd4, 8'h00);
            end
        end
        prio_tb[0] = 0;
        do_wr(3'd0, 8'h00);

        // R1 missed interrupt: second offer of a raised source is dropped
        do_offer(2);
        do_offer(2);
        chk(irq_o == 1, "R1 raised after offers", irq_o, 1);
        ack_expect(8'h42, "R1 first ack");
        ack_expect(8'hFF, "R1 missed offer not queued");
        do_wr(3'd4, 8'h00);

        // R4 highest priority first, tie to lower index
        do_offer(5); do_offer(3); do_offer(6);
        ack_expect(8'h46, "R4 highest first");
        ack_expect(8'h43, "R4 tie lowest index");
        ack_expect(8'h45, "R4 last");
        do_wr(3'd4, 8'h00); do_wr(3'd4, 8'h00); do_wr(3'd4, 8'h00);
        ack_expect(8'hFF, "R8 all retired");

        // R3 hidden by in-service, R8 rearm on eoi
        do_offer(6);
        ack_expect(8'h46, "R3 ack src6");
        chk(irq_o == 0, "R5 ack drops line", irq_o, 0);
        do_offer(5);
        chk(irq_o == 0, "R3 hidden below in-service", irq_o, 1'b0);
        do_wr(3'd4, 8'h00);
        chk(irq_o == 1, "R8 rearm with empty service", irq_o, 1);
        ack_expect(8'h45, "R8 ack after rearm");
        do_wr(3'd4, 8'h00);

        // R3 preemption, R8 partial retire
        do_offer(6);
        ack_expect(8'h46, "R3 ack src6 again");
        do_offer(4);
        chk(irq_o == 0, "R3 lower offer hidden", irq_o, 0);
        do_offer(1);
        chk(irq_o == 1, "R3 preempting offer", irq_o, 1);
        ack_expect(8'h41, "R3 ack src1");
        do_wr(3'd4, 8'h00);
        chk(irq_o == 0, "R8 no rearm below remaining service", irq_o, 0);
        do_wr(3'd4, 8'h00);
        chk(irq_o == 1, "R8 rearm after last retire", irq_o, 1);
        ack_expect(8'h44, "R8 ack src4");
        do_wr(3'd4, 8'h00);

        // R6 recheck against task priority at ack
        do_offer(4);
        do_wr(3'd0, 8'h08);
        ack_expect(8'hFF, "R6 priority recheck spurious");
        chk(act_o[4] == 0, "R6 activity cleared", act_o[4], 0);
        do_wr(3'd0, 8'h00);
        // R13 level drop then R6 inactive at ack
        do_offer(7);
        chk(act_o[7] == 1, "R2 activity set", act_o[7], 1);
        lvl_drop = 8'h80; @(negedge clk); lvl_drop = '0;
        chk(act_o[7] == 0, "R13 level drop clears activity", act_o[7], 0);
        ack_expect(8'hFF, "R6 inactive source spurious");
        // R9 spurious register value used
        do_wr(3'd1, 8'h3C);
        ack_expect(8'h3C, "R9 R5 programmed spurious");
        do_wr(3'd1, 8'hFF);

        // R7 edge vs level acknowledge
        do_offer(2);
        ack_expect(8'h42, "R7 edge ack");
        chk(pend_clr_o == 8'h04 && act_o[2] == 0, "R7 edge pend clear", {pend_clr_o, act_o}, 16'h0400 | (act_o & 8'hFB));
        @(negedge clk);
        chk(pend_clr_o == 8'h00, "R7 pulse one cycle", pend_clr_o, 0);
        do_wr(3'd4, 8'h00);
        do_offer(7);
        ack_expect(8'h47, "R7 level ack");
        chk(pend_clr_o == 0 && act_o[7] == 1, "R7 level keeps activity", {pend_clr_o, act_o[7]}, 1);
        do_wr(3'd4, 8'h00);
        lvl_drop = 8'h80; @(negedge clk); lvl_drop = '0;

        // R10 critical steering
        crit_en = 1'b1;
        do_offer(3);
        chk(cirq_o == 1 && irq_o == 0, "R10 critical line", {cirq_o, irq_o}, 2);
        ack_expect(8'h43, "R10 ack critical");
        chk(cirq_o == 0 && irq_o == 0, "R5 ack drops critical", {cirq_o, irq_o}, 0);
        do_wr(3'd4, 8'h00);
        crit_en = 1'b0;
        do_offer(3);
        chk(cirq_o == 0 && irq_o == 1, "R10 disabled uses normal", {cirq_o, irq_o}, 1);
        ack_expect(8'h43, "R10 ack normal");
        do_wr(3'd4, 8'h00);

        // R12 offer coinciding with register access is dropped
        offer_valid = 1'b1; offer_src = 3'd2;
        do_rd(3'd2);
        offer_valid = 1'b0;
        chk(irq_o == 0 && act_o[2] == 0, "R12 offer dropped", {irq_o, act_o[2]}, 0);
        chk(rv == 8'h00, "R11 identity during collision", rv, 0);
        ack_expect(8'hFF, "R12 nothing raised");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule